// File: doc/BRIEF.md
# Floating-Point Sticky Exception Flag Unit

This block sits beside a floating-point datapath. It turns the one-cycle status pulses that each completed operation reports into sticky flag bits of a floating-point control and status register. When the register's enable bit is set, each accepted status beat folds its causes into the flags. If any flag is then set, the block sends a one-cycle exception request to the core. The arithmetic is not part of the block.

Status arrives as a valid/ready stream of one 13-bit cause vector per beat. The block never applies back-pressure: `st_ready` is always high, so a beat is taken in every cycle that `st_valid` is high. Software reaches the register through a plain write port and a read-out bus. A write and a status beat in the same cycle are merged: the written value forms the base, and the beat's flags are ORed on top of it.

Status cause bit positions in `st_code`: 0 signalling NaN, 1 quiet NaN, 2 infinity minus infinity, 3 infinity over infinity, 4 zero over zero, 5 infinity times zero, 6 invalid conversion, 7 invalid compare, 8 invalid square root, 9 overflow, 10 underflow, 11 divide by zero, 12 inexact. Register bit positions: 0 enable, 1 invalid, 2 signalling NaN, 3 quiet NaN, 4 infinity, 5 overflow, 6 underflow, 7 divide by zero, 8 inexact.

Top module: `fpflag_unit`

## Requirements
- R1: After reset, `csr_rdata` is 0 and `exc_req` is low. `st_ready` is high at all times.
- R2: A write (`csr_wr` high) with no status beat loads `csr_wdata` into the register. `csr_rdata` shows the new value from the next cycle. A write alone never raises `exc_req`.
- R3: When the effective enable bit (bit 0) is clear, a status beat changes no register bit and raises no `exc_req`.
- R4: With the enable bit set, any of status bits 0 to 8 sets the invalid flag (register bit 1).
- R5: With the enable bit set, status bit 0 also sets register bit 2, and status bit 1 also sets register bit 3.
- R6: With the enable bit set, the infinity flag (register bit 4) is set by status bits 2 and 3 only. No other cause sets it.
- R7: With the enable bit set, status bits 9, 10, 11 and 12 set register bits 5, 6, 7 and 8 respectively, and no other flag.
- R8: Flags are sticky. Once set, a flag stays set through later beats, including beats that do not carry its cause. It clears only by a write or by reset.
- R9: `exc_req` is high for exactly the one cycle after an accepted beat with the effective enable set, and only if any of register bits 1 to 8 is set after that beat's update. Flags set by earlier beats count.
- R10: A write in the same cycle as a beat takes priority. The register becomes `csr_wdata` with the beat's flags ORed in, gated by bit 0 of `csr_wdata`. `exc_req` follows that merged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Status beat valid |
| st_ready | output | 1 | Status beat ready, always high |
| st_code | input | 13 | Status cause vector of the beat |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 9 | Register write value |
| csr_rdata | output | 9 | Current register value |
| exc_req | output | 1 | One-cycle floating-point exception request |

## Verification
Both results are registered. For a beat or write presented before rising edge N, `csr_rdata` and `exc_req` take their new values after edge N and hold them until edge N+1. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples both outputs on the next falling edge. It then samples once more a cycle later to confirm that `exc_req` has dropped. Ignored-beat cases are judged on `csr_rdata` and `exc_req` in that same sampling slot.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;
  // status cause vector layout
  localparam int ST_W     = 13;
  localparam int ST_SNAN  = 0;
  localparam int ST_QNAN  = 1;
  localparam int ST_ISI   = 2;
  localparam int ST_IDI   = 3;
  localparam int ST_NINV  = 9;   // causes 0..8 are invalid-operation causes
  localparam int ST_OVF   = 9;
  localparam int ST_NDIR  = 4;   // overflow, underflow, div-by-zero, inexact

  // register layout
  localparam int CSR_W    = 9;
  localparam int CSR_EN   = 0;
  localparam int NFLAG    = CSR_W - 1;
  // flag indices within the flag field (register bit minus one)
  localparam int FL_INV   = 0;
  localparam int FL_SNAN  = 1;
  localparam int FL_QNAN  = 2;
  localparam int FL_INF   = 3;
  localparam int FL_OVF   = 4;

  localparam logic [ST_W-1:0] INV_MASK = ST_W'((1 << ST_NINV) - 1);
  localparam logic [ST_W-1:0] INF_MASK = ST_W'((1 << ST_ISI) | (1 << ST_IDI));
endpackage

// File: rtl/fpflag_fold.sv
module fpflag_fold
  import fpflag_pkg::*;
(
  input  logic [ST_W-1:0]  code,
  output logic [NFLAG-1:0] flags
);
  logic inv_any;
  logic inf_any;

  assign inv_any = |(code & INV_MASK);
  assign inf_any = |(code & INF_MASK);

  assign flags[FL_INV]  = inv_any;
  assign flags[FL_SNAN] = code[ST_SNAN];
  assign flags[FL_QNAN] = code[ST_QNAN];
  assign flags[FL_INF]  = inf_any;

  // direct one-to-one causes
  for (genvar g = 0; g < ST_NDIR; g++) begin : g_direct
    assign flags[FL_OVF + g] = code[ST_OVF + g];
  end

  always_comb begin
    AST_INF_CAUSE: assert (!flags[FL_INF] || code[ST_ISI] || code[ST_IDI]); // R6
    AST_NAN_IMPLIES_INV: assert (!(flags[FL_SNAN] || flags[FL_QNAN]) || flags[FL_INV]); // R5
  end
endmodule

// File: rtl/fpflag_csr.sv
module fpflag_csr
  import fpflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [NFLAG-1:0] beat_flags,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  output logic [CSR_W-1:0] csr_q,
  output logic             req_q
);
  logic [CSR_W-1:0] base;
  logic [CSR_W-1:0] csr_d;
  logic             en_eff;
  logic             take;
  logic             req_d;

  // a write in the same cycle forms the base the beat is merged into
  assign base   = wr ? wdata : csr_q;
  assign en_eff = base[CSR_EN];
  assign take   = beat && en_eff;

  always_comb begin
    csr_d = base;
    if (take) csr_d[CSR_W-1:1] = base[CSR_W-1:1] | beat_flags;
  end

  assign req_d = take && (|csr_d[CSR_W-1:1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q <= '0;
      req_q <= 1'b0;
    end else begin
      csr_q <= csr_d;
      req_q <= req_d;
    end
  end

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !csr_q[CSR_EN]) |=> $stable(csr_q)); // R3

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((($past(csr_q) & ~csr_q)) == '0)); // R8

  AST_REQ_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ($past(beat) && csr_q[CSR_EN] && (|csr_q[CSR_W-1:1]))); // R9

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !beat) |=> (csr_q == $past(wdata) && !req_q)); // R2
endmodule

// File: rtl/fpflag_unit.sv
module fpflag_unit
  import fpflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [ST_W-1:0]  st_code,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             exc_req
);
  logic [NFLAG-1:0] beat_flags;
  logic             beat;

  assign st_ready = 1'b1;
  assign beat     = st_valid && st_ready;

  fpflag_fold u_fold (
    .code  (st_code),
    .flags (beat_flags)
  );

  fpflag_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .beat_flags (beat_flags),
    .wr         (csr_wr),
    .wdata      (csr_wdata),
    .csr_q      (csr_rdata),
    .req_q      (exc_req)
  );

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !$past(st_valid, 1)) |-> 1'b0); // R9
endmodule

// File: tb/fpflag_unit_tb_top.sv
module fpflag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [12:0] st_code = '0;
  logic        csr_wr = 1'b0;
  logic [8:0]  csr_wdata = '0;
  logic [8:0]  csr_rdata;
  logic        exc_req;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fpflag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_code(st_code), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .exc_req(exc_req)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one cycle of stimulus, sample on the falling edge after the rising edge
  task automatic step(input logic wr, input logic [8:0] wd, input logic v, input logic [12:0] c);
    @(negedge clk);
    csr_wr = wr; csr_wdata = wd; st_valid = v; st_code = c;
    @(negedge clk);
    csr_wr = 1'b0; st_valid = 1'b0; st_code = '0;
  endtask

  task automatic expect_out(input string req, input logic [8:0] csr_e, input logic req_e);
    chk(req, csr_rdata, csr_e);
    chk(req, {8'h0, exc_req}, {8'h0, req_e});
  endtask

  task automatic t_reset;
    expect_out("R1", 9'h000, 1'b0);
    chk("R1", {8'h0, st_ready}, 9'h001);
  endtask

  task automatic t_write;
    step(1'b1, 9'h0F0, 1'b0, '0);
    expect_out("R2", 9'h0F0, 1'b0);
    step(1'b1, 9'h001, 1'b0, '0);
    expect_out("R2", 9'h001, 1'b0);
  endtask

  task automatic t_disabled;
    step(1'b1, 9'h000, 1'b0, '0);
    step(1'b0, 9'h000, 1'b1, 13'h1FFF);
    expect_out("R3", 9'h000, 1'b0);
    step(1'b1, 9'h1E0, 1'b0, '0);
    step(1'b0, 9'h000, 1'b1, 13'h1FFF);
    expect_out("R3", 9'h1E0, 1'b0);
  endtask

  task automatic t_invalid;
    for (int i = 0; i < 9; i++) begin
      logic [8:0] e;
      e = 9'h003;
      if (i == 0) e[2] = 1'b1;
      if (i == 1) e[3] = 1'b1;
      if (i == 2 || i == 3) e[4] = 1'b1;
      step(1'b1, 9'h001, 1'b0, '0);
      step(1'b0, 9'h000, 1'b1, 13'(1 << i));
      if (i < 2) expect_out("R5", e, 1'b1);
      else if (i < 4) expect_out("R6", e, 1'b1);
      else expect_out("R4", e, 1'b1);
    end
  endtask

  task automatic t_direct;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 9'h001, 1'b0, '0);
      step(1'b0, 9'h000, 1'b1, 13'(1 << (9 + i)));
      expect_out("R7", 9'h001 | 9'(1 << (5 + i)), 1'b1);
    end
  endtask

  task automatic t_sticky;
    step(1'b1, 9'h001, 1'b0, '0);
    step(1'b0, 9'h000, 1'b1, 13'h0200);
    expect_out("R7", 9'h021, 1'b1);
    @(negedge clk);
    expect_out("R9", 9'h021, 1'b0);
    step(1'b0, 9'h000, 1'b1, 13'h0000);
    expect_out("R8", 9'h021, 1'b1);
    step(1'b0, 9'h000, 1'b1, 13'h1000);
    expect_out("R8", 9'h121, 1'b1);
    step(1'b1, 9'h001, 1'b0, '0);
    expect_out("R8", 9'h001, 1'b0);
    step(1'b0, 9'h000, 1'b1, 13'h0000);
    expect_out("R9", 9'h001, 1'b0);
    step(1'b1, 9'h003, 1'b0, '0);
    expect_out("R9", 9'h003, 1'b0);
  endtask

  task automatic t_collide;
    step(1'b1, 9'h021, 1'b0, '0);
    step(1'b1, 9'h001, 1'b1, 13'h0400);
    expect_out("R10", 9'h041, 1'b1);
    step(1'b1, 9'h000, 1'b1, 13'h0200);
    expect_out("R10", 9'h000, 1'b0);
    step(1'b1, 9'h081, 1'b1, 13'h0000);
    expect_out("R10", 9'h081, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_disabled();
        t_invalid();
        t_direct();
        t_sticky();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule